// File: doc/BRIEF.md
# Three-Phase Gate-Drive Output Stage with Dead-Time

This block turns three phase-timer PWM waveforms into six active-low gate-drive signals, one complementary pair per motor phase (U with U-bar, V with V-bar, W with W-bar). A per-leg inversion pattern is written into a holding register. It is copied into the working pattern register when a transfer trigger arrives. In triangular carrier mode the copy happens once per write. In sawtooth mode it happens on every trigger. Each phase has its own dead-time counter. While that counter runs, both legs of the phase are held off, so the leg about to turn on waits out a programmable gap.

The dead-time counter is reloaded from an 8-bit length register. It advances on a clock divided by four, which is the only legal count source. With the count source switched off, a started gap never ends. In triangular mode the gap starts only on a falling edge of the phase input. In sawtooth mode a transfer trigger also starts it on every phase. A shoot-through detector watches for both legs of any pair being driven at once and latches a flag. When the shutdown option is set, the same detection also blocks the outputs and drops the drive enable.

Per-phase dead-time control uses the states DT_IDLE (legs released) and DT_COUNT (gap in progress). DT_IDLE goes to DT_COUNT on a start when the length is nonzero. DT_COUNT goes back to DT_IDLE when the last divided tick brings the count to zero. A start while counting reloads the counter. Transfer control uses the states XF_IDLE (nothing pending) and XF_ARMED (a holding-register write awaits a trigger). A write moves the block to XF_ARMED. A trigger that copies the pattern returns it to XF_IDLE, unless a write arrives in the same cycle.

Top module: `tpwm_stage`

## Requirements
- R1: After reset all six gate outputs are high (inactive), drive enable is 0 and the shoot-through flag is 0.
- R2: Control write fields are: bit0 drive enable, bit1 sawtooth mode (0 = triangular), bit2 shutdown on shoot-through, bit3 count source (1 = clock/4, 0 = stopped), bit4 flag keep (0 clears the flag). While drive enable is 0 every gate output is high one cycle later. While it is 1 with a zero pattern, the high-side leg (even bit) is low when its phase input is high, and the low-side leg (odd bit) is low when its phase input is low. Gate bits are ordered U, U-bar, V, V-bar, W, W-bar from bit 0.
- R3: A falling edge on a phase input keeps both legs of that phase high for exactly 4×L cycles, where L is the dead-time length, with the count source set to clock/4.
- R4: In triangular mode a transfer trigger does not start a dead-time gap.
- R5: In sawtooth mode every transfer trigger starts a dead-time gap on all three phases.
- R6: In triangular mode a holding-register write takes effect only at the next transfer trigger, and only one copy follows each write.
- R7: In sawtooth mode every transfer trigger copies the holding register into the working pattern.
- R8: A working-pattern bit of 1 inverts the on/off sense of the gate leg at the same bit position.
- R9: A dead-time length of 0 gives no gap: the turning-on leg follows one cycle after the edge.
- R10: With the count source set to stopped, a started gap does not expire. It resumes once clock/4 is selected again.
- R11: The flag sets when drive enable is 1 and both legs of any pair are on. It stays set until a control write with flag keep 0, and a new detection wins over a clear in the same cycle.
- R12: With shutdown enabled, a detection drives every gate output high and clears drive enable on the next edge.
- R13: A control write with flag keep 1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_pwm | input | 3 | Phase timer outputs, bit 0 = U |
| xfer_trig | input | 1 | Transfer trigger pulse |
| wr_ctrl | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control write data (fields in R2) |
| wr_buf | input | 1 | Holding pattern write strobe |
| buf_wdata | input | 6 | Inversion pattern, one bit per gate leg |
| wr_dead | input | 1 | Dead-time length write strobe |
| dead_wdata | input | 8 | Dead-time length in clock/4 units |
| gate_n | output | 6 | Active-low gate drive, U, U-bar, V, V-bar, W, W-bar |
| drive_en | output | 1 | Current drive enable |
| short_flag | output | 1 | Latched shoot-through flag |

## Verification
The properties assume that every input is synchronous to the block clock and that the phase inputs are already free of metastability. They also assume that write strobes are single-cycle pulses. The gap property only applies to a phase whose two pattern bits are zero, because an inverted leg may legitimately be on during a gap. The stimulus changes inputs only on the falling clock edge, pulses each strobe for one cycle, and checks a gap only while that phase's pattern bits are clear. The bench's cycle model follows every pattern, mode and count-source change, so the per-cycle comparison holds across all of them.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    localparam int CTRL_W = 5;

    // Control write layout, MSB first: keep, src, shut, saw, enable
    typedef struct packed {
        logic flag_keep;
        logic src_div4;
        logic shut_en;
        logic saw_mode;
        logic drive_en;
    } ctrl_t;

    typedef enum logic {
        DT_IDLE,
        DT_COUNT
    } dt_state_e;

    typedef enum logic {
        XF_IDLE,
        XF_ARMED
    } xf_state_e;

endpackage

// File: rtl/tpwm_deadtime.sv
module tpwm_deadtime
    import tpwm_pkg::*;
#(
    parameter int DT_W  = 8,
    parameter int PRE_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            src_en,
    input  logic [DT_W-1:0] reload,
    output logic            busy
);

    localparam logic [PRE_W-1:0] PRE_LAST = '1;
    localparam logic [DT_W-1:0]  CNT_ONE  = DT_W'(1);

    dt_state_e        st_q, st_d;
    logic [DT_W-1:0]  cnt_q, cnt_d;
    logic [PRE_W-1:0] pre_q, pre_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DT_IDLE;
            cnt_q <= '0;
            pre_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            pre_q <= pre_d;
        end
    end

    // transitions and counting
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        pre_d = pre_q;
        unique case (st_q)
            DT_IDLE: begin
                st_d = DT_IDLE;
            end
            DT_COUNT: begin
                if (src_en) begin
                    pre_d = pre_q + 1'b1;
                    if (pre_q == PRE_LAST) begin
                        cnt_d = cnt_q - 1'b1;
                        if (cnt_q == CNT_ONE) begin
                            st_d = DT_IDLE;
                        end
                    end
                end
            end
        endcase
        if (start) begin
            cnt_d = reload;
            pre_d = '0;
            st_d  = (reload == '0) ? DT_IDLE : DT_COUNT;
        end
    end

    assign busy = (st_q == DT_COUNT);

endmodule

// File: rtl/tpwm_xfer.sv
module tpwm_xfer
    import tpwm_pkg::*;
#(
    parameter int LEGS = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_buf,
    input  logic [LEGS-1:0] buf_wdata,
    input  logic            trig,
    input  logic            saw_mode,
    output logic [LEGS-1:0] pattern
);

    xf_state_e       st_q, st_d;
    logic [LEGS-1:0] hold_q;
    logic [LEGS-1:0] work_q;
    logic            copy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= XF_IDLE;
            hold_q <= '0;
            work_q <= '0;
        end else begin
            st_q <= st_d;
            if (wr_buf) begin
                hold_q <= buf_wdata;
            end
            if (copy) begin
                work_q <= hold_q;
            end
        end
    end

    always_comb begin
        copy = 1'b0;
        st_d = st_q;
        unique case (st_q)
            XF_IDLE: begin
                copy = trig && saw_mode;
                if (wr_buf) begin
                    st_d = XF_ARMED;
                end
            end
            XF_ARMED: begin
                copy = trig;
                if (trig && !wr_buf) begin
                    st_d = XF_IDLE;
                end
            end
        endcase
    end

    assign pattern = work_q;

endmodule

// File: rtl/tpwm_stage.sv
module tpwm_stage
    import tpwm_pkg::*;
#(
    parameter int NUM_PH = 3,
    parameter int DT_W   = 8,
    parameter int PRE_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PH-1:0]   phase_pwm,
    input  logic                xfer_trig,
    input  logic                wr_ctrl,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic                wr_buf,
    input  logic [2*NUM_PH-1:0] buf_wdata,
    input  logic                wr_dead,
    input  logic [DT_W-1:0]     dead_wdata,
    output logic [2*NUM_PH-1:0] gate_n,
    output logic                drive_en,
    output logic                short_flag
);

    localparam int LEGS = 2 * NUM_PH;

    ctrl_t             wr_c;
    logic              en_q, saw_q, shut_q, src_q, flag_q;
    logic [DT_W-1:0]   dead_q;
    logic [NUM_PH-1:0] pwm_q;
    logic [NUM_PH-1:0] start;
    logic [NUM_PH-1:0] busy;
    logic [NUM_PH-1:0] pair_hit;
    logic [LEGS-1:0]   pattern;
    logic [LEGS-1:0]   leg_on;
    logic              both_on;
    logic              trip;

    assign wr_c = ctrl_t'(ctrl_wdata);

    tpwm_xfer #(.LEGS(LEGS)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_buf    (wr_buf),
        .buf_wdata (buf_wdata),
        .trig      (xfer_trig),
        .saw_mode  (saw_q),
        .pattern   (pattern)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        assign start[p] = (pwm_q[p] & ~phase_pwm[p]) | (saw_q & xfer_trig);

        tpwm_deadtime #(.DT_W(DT_W), .PRE_W(PRE_W)) u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (start[p]),
            .src_en (src_q),
            .reload (dead_q),
            .busy   (busy[p])
        );

        assign leg_on[2*p]   = (pwm_q[p] & ~busy[p]) ^ pattern[2*p];
        assign leg_on[2*p+1] = (~pwm_q[p] & ~busy[p]) ^ pattern[2*p+1];
        assign pair_hit[p]   = leg_on[2*p] & leg_on[2*p+1];
    end

    assign both_on = en_q & (|pair_hit);
    assign trip    = both_on & shut_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            saw_q  <= 1'b0;
            shut_q <= 1'b0;
            src_q  <= 1'b0;
            flag_q <= 1'b0;
            dead_q <= '0;
            pwm_q  <= '0;
            gate_n <= '1;
        end else begin
            pwm_q  <= phase_pwm;
            gate_n <= (en_q && !trip) ? ~leg_on : '1;
            if (wr_dead) begin
                dead_q <= dead_wdata;
            end
            if (wr_ctrl) begin
                saw_q  <= wr_c.saw_mode;
                shut_q <= wr_c.shut_en;
                src_q  <= wr_c.src_div4;
            end
            if (trip) begin
                en_q <= 1'b0;
            end else if (wr_ctrl) begin
                en_q <= wr_c.drive_en;
            end
            if (both_on) begin
                flag_q <= 1'b1;
            end else if (wr_ctrl && !wr_c.flag_keep) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign drive_en   = en_q;
    assign short_flag = flag_q;

endmodule

// File: rtl/tpwm_stage_chk.sv
module tpwm_stage_chk #(
    parameter int NUM_PH = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NUM_PH-1:0] gate_n,
    input logic                drive_en,
    input logic                short_flag,
    input logic                wr_ctrl,
    input logic                flag_keep,
    input logic                shut_q,
    input logic [NUM_PH-1:0]   busy,
    input logic [NUM_PH-1:0]   pair_hit,
    input logic [2*NUM_PH-1:0] pattern
);

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gate_n == '1) && !drive_en && !short_flag);

    // R2
    a_r2_off_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |=> (gate_n == '1));

    // R11
    a_r11_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && (|pair_hit)) |=> short_flag);

    // R11
    a_r11_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (short_flag && !(wr_ctrl && !flag_keep)) |=> short_flag);

    // R12
    a_r12_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && shut_q && (|pair_hit)) |=> (!drive_en && (gate_n == '1)));

    for (genvar p = 0; p < NUM_PH; p++) begin : g_gap
        // R3
        a_r3_gap_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[p] && (pattern[2*p+1 -: 2] == 2'b00)) |=> (gate_n[2*p+1 -: 2] == 2'b11));
    end

endmodule

bind tpwm_stage tpwm_stage_chk #(.NUM_PH(NUM_PH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_n     (gate_n),
    .drive_en   (drive_en),
    .short_flag (short_flag),
    .wr_ctrl    (wr_ctrl),
    .flag_keep  (ctrl_wdata[4]),
    .shut_q     (shut_q),
    .busy       (busy),
    .pair_hit   (pair_hit),
    .pattern    (pattern)
);

// File: tb/tpwm_stage_tb.sv
`timescale 1ns/1ps
module tpwm_stage_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pwm = 3'b000;
    logic       trig = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [4:0] cdata = 5'b0;
    logic       wr_buf = 1'b0;
    logic [5:0] bdata = 6'b0;
    logic       wr_dead = 1'b0;
    logic [7:0] ddata = 8'b0;
    logic [5:0] gate_n;
    logic       drive_en;
    logic       short_flag;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    tpwm_stage u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_pwm  (pwm),
        .xfer_trig  (trig),
        .wr_ctrl    (wr_ctrl),
        .ctrl_wdata (cdata),
        .wr_buf     (wr_buf),
        .buf_wdata  (bdata),
        .wr_dead    (wr_dead),
        .dead_wdata (ddata),
        .gate_n     (gate_n),
        .drive_en   (drive_en),
        .short_flag (short_flag)
    );

    // behavioural reference: remaining gap cycles per phase, pending copy flag
    bit [2:0] m_pwm;
    int       m_rem [3];
    bit       m_en, m_saw, m_shut, m_src, m_flag, m_pend;
    bit [5:0] m_buf, m_work, m_gate = 6'h3f, m_on;
    bit [7:0] m_dead;
    bit       m_both, m_trip, m_copy;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pwm = 0; m_en = 0; m_saw = 0; m_shut = 0; m_src = 0; m_flag = 0;
            m_pend = 0; m_buf = 0; m_work = 0; m_gate = 6'h3f; m_dead = 0;
            for (int p = 0; p < 3; p++) m_rem[p] = 0;
        end else begin
            m_both = 0;
            for (int p = 0; p < 3; p++) begin
                m_on[2*p]   = (m_pwm[p] && m_rem[p] == 0) ^ m_work[2*p];
                m_on[2*p+1] = (!m_pwm[p] && m_rem[p] == 0) ^ m_work[2*p+1];
                if (m_en && m_on[2*p] && m_on[2*p+1]) m_both = 1;
            end
            m_trip = m_both && m_shut;
            m_gate = (m_en && !m_trip) ? ~m_on : 6'h3f;
            if (m_both) m_flag = 1;
            else if (wr_ctrl && !cdata[4]) m_flag = 0;
            if (m_trip) m_en = 0;
            else if (wr_ctrl) m_en = cdata[0];
            for (int p = 0; p < 3; p++) begin
                if ((m_pwm[p] && !pwm[p]) || (m_saw && trig)) m_rem[p] = 4 * m_dead;
                else if (m_rem[p] > 0 && m_src) m_rem[p] = m_rem[p] - 1;
            end
            m_copy = trig && (m_saw || m_pend);
            if (m_copy) begin m_work = m_buf; m_pend = 0; end
            if (wr_buf) begin m_buf = bdata; m_pend = 1; end
            if (wr_ctrl) begin m_saw = cdata[1]; m_shut = cdata[2]; m_src = cdata[3]; end
            if (wr_dead) m_dead = ddata;
            m_pwm = pwm;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (gate_n !== m_gate || drive_en !== m_en || short_flag !== m_flag) begin
                bad++;
                $display("FAIL %s: gate_n=%b drive_en=%b flag=%b expected %b %b %b",
                         cur_req, gate_n, drive_en, short_flag, m_gate, m_en, m_flag);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wctrl(input logic [4:0] v);
        wr_ctrl = 1; cdata = v; @(negedge clk); wr_ctrl = 0;
    endtask

    task automatic wbuf(input logic [5:0] v);
        wr_buf = 1; bdata = v; @(negedge clk); wr_buf = 0;
    endtask

    task automatic wdead(input logic [7:0] v);
        wr_dead = 1; ddata = v; @(negedge clk); wr_dead = 0;
    endtask

    task automatic pulse;
        trig = 1; @(negedge clk); trig = 0;
    endtask

    // ctrl encodings: {keep, src, shut, saw, en}
    localparam logic [4:0] C_TRI   = 5'b11001;
    localparam logic [4:0] C_SAW   = 5'b11011;
    localparam logic [4:0] C_STOP  = 5'b10001;
    localparam logic [4:0] C_SHUT  = 5'b11101;
    localparam logic [4:0] C_CLEAR = 5'b01001;

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        cur_req = "R1";
        chk("R1", gate_n, 6'h3f);
        chk("R1", drive_en, 0);
        chk("R1", short_flag, 0);

        cur_req = "R2";
        pwm = 3'b101; cyc(4); pwm = 3'b000; cyc(4);
        chk("R2", gate_n, 6'h3f);
        wdead(8'd3);
        wctrl(C_TRI);
        cyc(5);
        chk("R2", gate_n, 6'b010101);

        cur_req = "R3";
        pwm[0] = 1; cyc(20);
        pwm[0] = 0; cyc(7);
        chk("R3", gate_n[1:0], 2'b11);
        cyc(15);
        chk("R3", gate_n[1:0], 2'b01);

        cur_req = "R4";
        pulse; cyc(2);
        chk("R4", gate_n, 6'b010101);
        cyc(5);

        cur_req = "R5";
        wctrl(C_SAW);
        pulse; cyc(2);
        chk("R5", gate_n, 6'h3f);
        cyc(15);

        cur_req = "R6";
        wctrl(C_TRI);
        wbuf(6'b000011);
        cyc(10);
        chk("R6", gate_n[1:0], 2'b01);
        pulse; cyc(3);
        cur_req = "R8";
        chk("R8", gate_n[1:0], 2'b10);
        cur_req = "R6";
        pulse; cyc(3); pulse; cyc(3);
        chk("R6", gate_n[1:0], 2'b10);

        cur_req = "R7";
        wctrl(C_SAW);
        wbuf(6'b000000);
        pulse; cyc(20);
        chk("R7", gate_n, 6'b010101);
        wbuf(6'b001100);
        pulse; cyc(20);
        chk("R7", gate_n[3:2], 2'b10);
        wbuf(6'b000000);
        pulse; cyc(20);

        cur_req = "R9";
        wctrl(C_TRI);
        wdead(8'd0);
        pwm[1] = 1; cyc(3);
        pwm[1] = 0; cyc(2);
        chk("R9", gate_n[3:2], 2'b01);
        cyc(3);

        cur_req = "R10";
        wdead(8'd2);
        wctrl(C_STOP);
        pwm[2] = 1; cyc(5);
        pwm[2] = 0; cyc(40);
        chk("R10", gate_n[5:4], 2'b11);
        wctrl(C_TRI);
        cyc(20);
        chk("R10", gate_n[5:4], 2'b01);

        cur_req = "R11";
        wbuf(6'b000001);
        pulse; cyc(5);
        chk("R11", short_flag, 1);
        chk("R11", drive_en, 1);
        chk("R11", gate_n[1:0], 2'b00);
        wbuf(6'b000000);
        pulse; cyc(5);
        chk("R11", short_flag, 1);
        cur_req = "R13";
        wctrl(C_TRI); cyc(2);
        chk("R13", short_flag, 1);
        cur_req = "R11";
        wctrl(C_CLEAR); cyc(2);
        chk("R11", short_flag, 0);

        cur_req = "R12";
        wctrl(C_SHUT);
        wbuf(6'b000001);
        pulse; cyc(3);
        chk("R12", drive_en, 0);
        chk("R12", gate_n, 6'h3f);
        chk("R12", short_flag, 1);
        wbuf(6'b000000);
        pulse; cyc(2);
        wctrl(C_CLEAR); cyc(10);
        chk("R12", drive_en, 1);
        chk("R12", gate_n, 6'b010101);

        cyc(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule